// File: doc/BRIEF.md
# HDLC Transmit Framer

This block turns a stream of bytes into a serial HDLC bit stream, one line bit per cycle of the transmit clock. A byte source hands it bytes over a valid/ready handshake and marks the final byte of each frame. The framer sends an opening flag and then the payload bits, least significant bit first. It appends a 16-bit frame check sequence that it computes from the serial bits as they go out, and it ends the frame with a closing flag. Between frames the line is held at one.

Inside frame content, meaning payload and check sequence, a zero is inserted after every run of five ones. Flags are never stuffed. If the source has no byte ready when the framer needs one, the framer abandons the frame with an abort run of ones. An explicit abort command does the same. A control input makes the framer send the check sequence with its bits inverted, so that a receiver's error path can be exercised.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While rst_ni is low, tx_o is 1 and ready_o is 0.
- R2: With no frame in progress the line is continuously 1, and abort_i has no effect on tx_o or ready_o.
- R3: A frame begins and ends with the flag 0x7E, sent LSB first as the bit order 0,1,1,1,1,1,1,0. No zero is ever inserted inside a flag.
- R4: A frame starts when valid_i is high while the framer is idle. Each byte is taken when ready_o and valid_i are both high at a clock edge, and it is sent LSB first. The byte taken with last_i high is the final payload byte.
- R5: In payload and check sequence bits, a 0 is inserted after every five consecutive 1 bits. This includes a run that completes on the last check bit, before the closing flag.
- R6: The check sequence is CRC-16 with polynomial x^16+x^12+x^5+1 (0x8408 in reflected form). It is preset to 0xFFFF, computed over the payload bits, and sent complemented, LSB first.
- R7: bad_fcs_i is sampled together with the final byte. When it is 1, the 16 check bits go out uncomplemented, which is every check bit inverted.
- R8: If valid_i is low when the framer needs the next byte of a frame (no last byte taken yet), the frame is aborted. The line gives at least seven 1 bits, no check sequence or closing flag is sent, and the line stays at idle 1.
- R9: abort_i high at a clock edge during a frame aborts it in the same way, and ready_o is held low in that cycle.
- R10: After an abort, the next frame starts with a fresh opening flag and has a correct check sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Transmit bit clock, one line bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Payload byte from the source |
| valid_i | input | 1 | Source has a byte on byte_i |
| last_i | input | 1 | The byte on byte_i ends the frame |
| bad_fcs_i | input | 1 | Send the check sequence of this frame inverted |
| abort_i | input | 1 | Abort the frame in progress |
| ready_o | output | 1 | Framer takes byte_i at this edge if valid_i is high |
| tx_o | output | 1 | Serial line output (registered) |

## Verification
Every cycle the assertions check four things. An idle or abort state must put a 1 on the line. A stuff decision must put a 0 on the line. A missing byte must lead to the abort state, and so must an abort command issued during a frame. Flag shape, bit order, the stuffing positions and the check-sequence value can only be confirmed by the bench. It rebuilds each expected frame bit by bit from the requirements and compares it with the captured line, for payloads full of ones, payloads that contain flag bytes, inverted check sequences, underflow, a commanded abort and the frame that follows it.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_DATA,
    ST_FCS,
    ST_CLOSE,
    ST_ABORT
  } tx_state_e;

  localparam logic [7:0] FLAG_PAT = 8'h7E;
endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
  parameter int unsigned   W      = 16,
  parameter logic [W-1:0] POLY_R = 16'h8408,
  parameter logic [W-1:0] INIT   = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         upd_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q;
  logic         fb;

  assign fb    = crc_q[0] ^ bit_i;
  assign crc_o = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= INIT;
    else if (init_i)  crc_q <= INIT;
    else if (upd_i)   crc_q <= (crc_q >> 1) ^ (fb ? POLY_R : '0);
    else if (shift_i) crc_q <= crc_q >> 1;  // drain toward bit 0 for output
  end
endmodule

// File: rtl/hdlc_tx_stuffer.sv
module hdlc_tx_stuffer #(
  parameter int unsigned RUN_LEN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic content_i,
  input  logic bit_i,
  output logic full_o
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] cnt_q;

  assign full_o = (cnt_q == CW'(RUN_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (en_i && full_o)   cnt_q <= '0;
    else if (content_i)        cnt_q <= bit_i ? cnt_q + 1'b1 : '0;
    else                       cnt_q <= '0;  // flags and idle break the run
  end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned    DATA_W     = 8,
  parameter int unsigned    FCS_W      = 16,
  parameter int unsigned    ABORT_LEN  = 8,
  parameter int unsigned    RUN_LEN    = 5,
  parameter logic [FCS_W-1:0] FCS_POLY_R = 16'h8408
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              valid_i,
  input  logic              last_i,
  input  logic              bad_fcs_i,
  input  logic              abort_i,
  output logic              ready_o,
  output logic              tx_o
);
  localparam int unsigned BC_W = $clog2(DATA_W);
  localparam int unsigned FC_W = $clog2(FCS_W);
  localparam int unsigned AC_W = $clog2(ABORT_LEN);

  tx_state_e         state_q, state_d;
  logic [DATA_W-1:0] sh_q;
  logic [BC_W-1:0]   bit_cnt_q;
  logic [FC_W-1:0]   fcs_cnt_q;
  logic [AC_W-1:0]   ab_cnt_q;
  logic              last_q, bad_q, tx_q;

  logic              run_full, stuff_en, stuff_now;
  logic              byte_end, fcs_end, ab_end, load_slot;
  logic              cur_bit, content_bit;
  logic [FCS_W-1:0]  crc;

  assign stuff_en  = state_q inside {ST_DATA, ST_FCS, ST_CLOSE};
  assign stuff_now = stuff_en & run_full;
  assign byte_end  = (bit_cnt_q == BC_W'(DATA_W - 1));
  assign fcs_end   = (fcs_cnt_q == FC_W'(FCS_W - 1));
  assign ab_end    = (ab_cnt_q == AC_W'(ABORT_LEN - 1));
  assign load_slot = ~stuff_now & byte_end &
                     ((state_q == ST_OPEN) | ((state_q == ST_DATA) & ~last_q));
  assign ready_o   = load_slot & ~abort_i;
  assign content_bit = ~stuff_now & (state_q inside {ST_DATA, ST_FCS});
  assign tx_o      = tx_q;

  always_comb begin
    unique case (state_q)
      ST_OPEN:  cur_bit = sh_q[0];
      ST_DATA:  cur_bit = stuff_now ? 1'b0 : sh_q[0];
      ST_FCS:   cur_bit = stuff_now ? 1'b0 : (bad_q ? crc[0] : ~crc[0]);
      ST_CLOSE: cur_bit = stuff_now ? 1'b0 : sh_q[0];
      default:  cur_bit = 1'b1;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (valid_i) state_d = ST_OPEN;
      ST_OPEN: begin
        if (abort_i)       state_d = ST_ABORT;
        else if (byte_end) state_d = valid_i ? ST_DATA : ST_ABORT;
      end
      ST_DATA: begin
        if (abort_i) state_d = ST_ABORT;
        else if (~stuff_now && byte_end)
          state_d = last_q ? ST_FCS : (valid_i ? ST_DATA : ST_ABORT);
      end
      ST_FCS: begin
        if (abort_i)                    state_d = ST_ABORT;
        else if (~stuff_now && fcs_end) state_d = ST_CLOSE;
      end
      ST_CLOSE: begin
        if (abort_i)                     state_d = ST_ABORT;
        else if (~stuff_now && byte_end) state_d = ST_IDLE;
      end
      ST_ABORT: if (ab_end) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sh_q      <= '0;
      bit_cnt_q <= '0;
      fcs_cnt_q <= '0;
      ab_cnt_q  <= '0;
      last_q    <= 1'b0;
      bad_q     <= 1'b0;
      tx_q      <= 1'b1;
    end else begin
      tx_q    <= cur_bit;
      state_q <= state_d;
      if (state_q == ST_IDLE) begin
        sh_q      <= DATA_W'(FLAG_PAT);
        bit_cnt_q <= '0;
        fcs_cnt_q <= '0;
        last_q    <= 1'b0;
      end else if (state_q inside {ST_OPEN, ST_DATA, ST_CLOSE}) begin
        if (~stuff_now) begin
          bit_cnt_q <= byte_end ? '0 : bit_cnt_q + 1'b1;
          sh_q      <= sh_q >> 1;
        end
        if (ready_o && valid_i) begin
          sh_q   <= byte_i;
          last_q <= last_i;
          bad_q  <= bad_fcs_i;
        end
      end else if (state_q == ST_FCS && ~stuff_now) begin
        fcs_cnt_q <= fcs_cnt_q + 1'b1;
        if (fcs_end) sh_q <= DATA_W'(FLAG_PAT);
      end
      if (state_d == ST_ABORT && state_q != ST_ABORT) ab_cnt_q <= '0;
      else if (state_q == ST_ABORT)                    ab_cnt_q <= ab_cnt_q + 1'b1;
    end
  end

  hdlc_tx_stuffer #(.RUN_LEN(RUN_LEN)) u_stuff (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (stuff_en),
    .content_i(content_bit),
    .bit_i    (cur_bit),
    .full_o   (run_full)
  );

  hdlc_tx_crc #(.W(FCS_W), .POLY_R(FCS_POLY_R), .INIT('1)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (state_q == ST_IDLE),
    .upd_i  (~stuff_now && state_q == ST_DATA),
    .shift_i(~stuff_now && state_q == ST_FCS),
    .bit_i  (sh_q[0]),
    .crc_o  (crc)
  );
endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk
  import hdlc_tx_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      tx_o,
  input logic      valid_i,
  input logic      abort_i,
  input logic      stuff_now,
  input logic      load_slot,
  input tx_state_e state_q
);
  a_r2_idle_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |=> tx_o);

  a_r8_abort_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ABORT |=> tx_o);

  a_r5_stuff_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff_now |=> !tx_o);

  a_r8_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_slot && !valid_i && !abort_i |=> state_q == ST_ABORT);

  a_r9_abort_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i && (state_q inside {ST_OPEN, ST_DATA, ST_FCS, ST_CLOSE}) |=> state_q == ST_ABORT);
endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tx_o     (tx_o),
  .valid_i  (valid_i),
  .abort_i  (abort_i),
  .stuff_now(stuff_now),
  .load_slot(load_slot),
  .state_q  (state_q)
);

// File: tb/tb_hdlc_tx_framer.sv
module tb_hdlc_tx_framer;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  localparam int CAP_MAX = 512;

  typedef struct packed {
    logic [2:0]  len;
    logic [31:0] data;
    logic        bad;
    logic        uflow;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{3'd1, 32'h0000_0055, 1'b0, 1'b0},  // single byte
    '{3'd2, 32'h0000_FFFF, 1'b0, 1'b0},  // long ones runs
    '{3'd3, 32'h0001_3F7E, 1'b0, 1'b0},  // flag byte as payload
    '{3'd2, 32'h0000_3412, 1'b1, 1'b0},  // inverted check bits
    '{3'd2, 32'h0000_0FF0, 1'b0, 1'b1}   // source runs dry
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] byte_i = '0;
  logic       valid_i = 1'b0, last_i = 1'b0, bad_fcs_i = 1'b0, abort_i = 1'b0;
  logic       ready_o, tx_o;

  logic cap [CAP_MAX];
  logic expb [CAP_MAX];
  int   cap_n = 0, exp_n = 0, ones = 0, hs = 0;
  bit   cap_en = 1'b0;
  int   total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_tx_framer dut (
    .clk_i(clk), .rst_ni(rst_ni), .byte_i(byte_i), .valid_i(valid_i), .last_i(last_i),
    .bad_fcs_i(bad_fcs_i), .abort_i(abort_i), .ready_o(ready_o), .tx_o(tx_o)
  );

  always @(negedge clk) if (cap_en && cap_n < CAP_MAX) begin
    cap[cap_n] = tx_o;
    cap_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push_content(input logic b);
    expb[exp_n] = b; exp_n++;
    ones = b ? ones + 1 : 0;
    if (ones == 5) begin expb[exp_n] = 1'b0; exp_n++; ones = 0; end
  endtask

  task automatic push_flag();
    for (int i = 0; i < 8; i++) begin expb[exp_n] = (i != 0 && i != 7); exp_n++; end
    ones = 0;
  endtask

  task automatic build(input vec_t v, input int nb, input bit full);
    logic [15:0] crc;
    logic [15:0] fcs;
    logic        b, fb;
    exp_n = 0; ones = 0; crc = 16'hFFFF;
    push_flag();
    for (int k = 0; k < nb; k++)
      for (int i = 0; i < 8; i++) begin
        b = v.data[8*k + i];
        push_content(b);
        fb = crc[0] ^ b;
        crc = (crc >> 1) ^ (fb ? 16'h8408 : 16'h0000);
      end
    if (full) begin
      fcs = v.bad ? crc : ~crc;
      for (int i = 0; i < 16; i++) push_content(fcs[i]);
      push_flag();
    end
  endtask

  // compare captured line with expected, then require only ones afterwards
  task automatic check_stream(input string req, input int extra);
    int s; int mis; int tail;
    s = -1; mis = -1;
    for (int i = 0; i < cap_n; i++) if (s < 0 && cap[i] == 1'b0) s = i;
    if (s < 0) begin chk(0, req, -1, 0); return; end
    for (int k = 0; k < exp_n; k++)
      if (mis < 0 && (s + k >= cap_n || cap[s+k] !== expb[k])) mis = k;
    if (mis >= 0) begin chk(0, req, int'(cap[s+mis]), int'(expb[mis])); return; end
    tail = 0;
    for (int i = s + exp_n + extra; i < cap_n; i++) begin
      if (cap[i] !== 1'b1) mis = i;
      tail++;
    end
    chk(mis < 0 && tail >= 8, req, mis, -1);
  endtask

  task automatic send(input vec_t v, input int abort_at);
    int i; int guard;
    i = 0; guard = 0;
    @(negedge clk);
    valid_i = 1'b1; byte_i = v.data[7:0];
    last_i = (v.len == 1) && !v.uflow; bad_fcs_i = v.bad;
    while (i < int'(v.len) && guard < 2000) begin
      @(negedge clk); guard++;
      if (ready_o) begin
        @(posedge clk); #1; i++;
        if (i == abort_at) begin
          valid_i = 1'b0; last_i = 1'b0; abort_i = 1'b1;
          @(posedge clk); #1; abort_i = 1'b0;
          break;
        end
        if (i < int'(v.len)) begin
          byte_i = v.data[8*i +: 8];
          last_i = (i == int'(v.len) - 1) && !v.uflow;
        end else begin
          valid_i = 1'b0; last_i = 1'b0;
        end
      end
    end
    valid_i = 1'b0;
    hs = i;
  endtask

  task automatic run_frame(input vec_t v, input int abort_at);
    cap_n = 0; cap_en = 1'b1;
    send(v, abort_at);
    repeat (150) @(negedge clk);
    cap_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vec_t va, vr;
    repeat (3) @(negedge clk);
    chk(tx_o === 1'b1, "R1 tx_o in reset", int'(tx_o), 1);
    chk(ready_o === 1'b0, "R1 ready_o in reset", int'(ready_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R2: abort_i while idle must not disturb the line
    cap_n = 0; cap_en = 1'b1; abort_i = 1'b1;
    begin
      int rdy; rdy = 0;
      repeat (20) begin @(negedge clk); if (ready_o) rdy++; end
      abort_i = 1'b0; cap_en = 1'b0;
      begin
        int zeros; zeros = 0;
        for (int i = 0; i < cap_n; i++) if (cap[i] !== 1'b1) zeros++;
        chk(zeros == 0 && rdy == 0, "R2 idle ignores abort_i", zeros + rdy, 0);
      end
    end

    // table walk: R3 R4 R5 R6 R7 R8
    for (int k = 0; k < NV; k++) begin
      run_frame(VECS[k], 0);
      build(VECS[k], int'(VECS[k].len), !VECS[k].uflow);
      if (VECS[k].uflow) check_stream("R8 underflow abort stream", 0);
      else if (VECS[k].bad) check_stream("R7 inverted FCS stream", 0);
      else check_stream("R3 R4 R5 R6 frame stream", 0);
      chk(hs == int'(VECS[k].len), "R4 handshake count", hs, int'(VECS[k].len));
    end

    // R9: commanded abort just after the third byte is taken
    va = '{3'd4, 32'h8844_2211, 1'b0, 1'b0};
    run_frame(va, 3);
    build(va, 2, 1'b0);
    check_stream("R9 abort command stream", 1);
    chk(hs == 3, "R9 bytes taken before abort", hs, 3);

    // R10: clean frame after an abort
    vr = '{3'd2, 32'h0000_A5C3, 1'b0, 1'b0};
    run_frame(vr, 0);
    build(vr, 2, 1'b1);
    check_stream("R10 frame after abort", 0);
    chk(hs == 2, "R10 handshake count", hs, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule